// File: doc/BRIEF.md
# Double-Edge Display Data Loader

This block fills a bank of per-channel grayscale holding registers from a parallel byte bus. An external shift clock paces the transfer, and a byte is taken on each of its transitions, rising and falling alike. A group of 16 shift clock pulses therefore supplies one byte to each of the 32 channels. The shift clock is not used as a clock inside the block. It is synchronized onto a faster system clock, and every detected level change becomes a one-cycle load strobe. The bus is delayed through a pipeline of the same depth, so each strobe stores the byte that was present when the new shift clock level was first sampled.

A chip-select input pulse opens a load window, and the channel pointer restarts at the first channel. Each strobe inside the window stores the bus byte into the next channel in increasing order. The window closes once the last channel has been written. One system clock later, the block raises a chip-select output pulse one cycle wide, which starts the window of the next driver in a chain. The holding registers keep their values between windows, so a downstream pulse-width stage can read them steadily. Strobes outside a window, and chip-select pulses that arrive while a window is open, change nothing.

Both the byte bus and the shift clock come from outside the block and cannot be paused. For that reason there is no valid/ready handshake and no back-pressure: a strobe inside an open window always stores.

Top module: `dedge_byte_loader`

## Requirements
- R1: While the synchronous reset `rst` is high, every channel register reads 0 and `cs_out_o` is low. After reset the load window is closed.
- R2: A rising transition of `shclk_i` and a falling transition each store one byte. The first edge after the window opens writes channel 1, and the edge that follows it writes channel 2, whatever the edge directions are.
- R3: Bytes go to the channels in strictly increasing order. Channel k (1-based) is the lane `chan_o[(k-1)*8 +: 8]`, so the 32nd edge of a group writes lane bits 255:248.
- R4: After the 32nd byte the window closes. Later shift clock edges leave every channel unchanged until a new chip-select pulse arrives.
- R5: `cs_out_o` is high for exactly one system clock cycle, in the cycle after the 32nd byte is stored. Each accepted chip-select pulse produces exactly one such pulse.
- R6: Shift clock edges that arrive while no window is open store nothing.
- R7: A rising level on `cs_in_i` opens the window and resets the pointer to channel 1. A rising level that arrives while a window is already open is ignored, and loading continues at the current channel.
- R8: With SYNC_STAGES=2, take a `shclk_i` transition that is first sampled at system clock edge k. Its byte is the `bus_i` value sampled at edge k, and that byte becomes visible on `chan_o` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be faster than twice the shift clock rate |
| rst | input | 1 | Synchronous reset, active high |
| shclk_i | input | 1 | Shift clock, asynchronous, both edges are used |
| bus_i | input | DATA_W (8) | Grayscale byte bus |
| cs_in_i | input | 1 | Chip-select input; a rising level opens a load window |
| cs_out_o | output | 1 | Chip-select output, one-cycle pulse after the last channel is written |
| chan_o | output | NUM_CH*DATA_W (256) | All channel registers, channel 1 in the lowest byte |

## Verification
The bench builds the block with its default values: 8-bit bytes, 32 channels and a two-stage synchronizer. It therefore exercises the real wrap from the last channel to closing the window and emitting the chip-select output. A group costs only about 230 system clocks, so several full groups fit in one run. These cover a chip-select pulse in the middle of a window, shift clock edges while the window is closed, and an exact measurement of the latency from edge to register. A queue-based model of the shift clock and bus history predicts every channel byte and the chip-select output on each cycle.

// File: rtl/dload_pkg.sv
package dload_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;
endpackage

// File: rtl/dload_edge_sync.sv
// Brings the shift clock into the system clock domain, emits a strobe on
// every level change and delays the bus by the same depth.
module dload_edge_sync #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sh_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              strobe_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [DATA_W-1:0]      bus_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      for (int i = 0; i < SYNC_STAGES; i++) bus_q[i] <= '0;
    end else begin
      sync_q[0] <= sh_i;
      bus_q[0]  <= bus_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
        bus_q[i]  <= bus_q[i-1];
      end
      prev_q <= sync_q[LAST];
    end
  end

  assign strobe_o = sync_q[LAST] ^ prev_q;
  assign byte_o   = bus_q[LAST];
endmodule

// File: rtl/dload_ctrl.sv
// Load window, channel pointer and chip-select hand-off.
module dload_ctrl
  import dload_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int PTR_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_in_i,
  input  logic             strobe_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             win_o,
  output logic             cs_out_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_CH - 1);

  win_state_e       state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             cs_q;
  logic             last_q;
  logic             cso_q;
  logic             cs_rise;

  assign cs_rise  = cs_in_i & ~cs_q;
  assign win_o    = (state_q == WIN_OPEN);
  assign wr_en_o  = win_o & strobe_i;
  assign wr_ptr_o = ptr_q;
  assign cs_out_o = cso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WIN_IDLE;
      ptr_q   <= '0;
      cs_q    <= 1'b0;
      last_q  <= 1'b0;
      cso_q   <= 1'b0;
    end else begin
      cs_q   <= cs_in_i;
      last_q <= 1'b0;
      cso_q  <= last_q;
      case (state_q)
        WIN_IDLE: begin
          if (cs_rise) begin
            state_q <= WIN_OPEN;
            ptr_q   <= '0;
          end
        end
        WIN_OPEN: begin
          if (strobe_i) begin
            if (ptr_q == PTR_LAST) begin
              state_q <= WIN_IDLE;
              ptr_q   <= '0;
              last_q  <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        default: state_q <= WIN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dload_bank.sv
// One holding register per channel, written by pointer.
module dload_bank #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 32,
  parameter int PTR_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [PTR_W-1:0]         wr_ptr_i,
  input  logic [DATA_W-1:0]        wr_byte_i,
  output logic [NUM_CH*DATA_W-1:0] chan_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                                      lane_q <= '0;
      else if (wr_en_i && wr_ptr_i == PTR_W'(g))    lane_q <= wr_byte_i;
    end
    assign chan_o[g*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/dedge_byte_loader.sv
module dedge_byte_loader #(
  parameter int DATA_W      = 8,
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shclk_i,
  input  logic [DATA_W-1:0]        bus_i,
  input  logic                     cs_in_i,
  output logic                     cs_out_o,
  output logic [NUM_CH*DATA_W-1:0] chan_o
);
  localparam int PTR_W = $clog2(NUM_CH);

  logic              strobe;
  logic [DATA_W-1:0] cap_byte;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_ptr;
  logic              win_open;

  dload_edge_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sh_i(shclk_i), .bus_i(bus_i),
    .strobe_o(strobe), .byte_o(cap_byte)
  );

  dload_ctrl #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_in_i(cs_in_i), .strobe_i(strobe),
    .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .win_o(win_open), .cs_out_o(cs_out_o)
  );

  dload_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
    .wr_byte_i(cap_byte), .chan_o(chan_o)
  );
endmodule

// File: rtl/dload_checker.sv
module dload_checker #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 32,
  parameter int PTR_W  = $clog2(NUM_CH)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_out_o,
  input logic [NUM_CH*DATA_W-1:0] chan_o,
  input logic                     win_open,
  input logic                     strobe,
  input logic [PTR_W-1:0]         wr_ptr
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_CH - 1);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (chan_o == '0 && !cs_out_o));                                // R1
  AST_CSO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cs_out_o |=> !cs_out_o);                                             // R5
  AST_CSO_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    cs_out_o |-> (!win_open && !$past(win_open) && $past(win_open, 2))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(chan_o));                                      // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (win_open && strobe && wr_ptr != PTR_LAST) |=>
      (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));                         // R3
  AST_OPEN_AT_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open) |-> (wr_ptr == '0));                                 // R7
endmodule

bind dedge_byte_loader dload_checker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .cs_out_o(cs_out_o), .chan_o(chan_o),
  .win_open(win_open), .strobe(strobe), .wr_ptr(wr_ptr)
);

// File: tb/dedge_byte_loader_bench.sv
`timescale 1ns/1ps
module dedge_byte_loader_bench;
  localparam int DW  = 8;
  localparam int NCH = 32;
  localparam int S   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              shclk_i = 1'b0;
  logic [DW-1:0]     bus_i = '0;
  logic              cs_in_i = 1'b0;
  logic              cs_out_o;
  logic [NCH*DW-1:0] chan_o;

  always #4 clk = ~clk;

  dedge_byte_loader #(.DATA_W(DW), .NUM_CH(NCH), .SYNC_STAGES(S)) u_dedge_byte_loader (
    .clk(clk), .rst(rst), .shclk_i(shclk_i), .bus_i(bus_i),
    .cs_in_i(cs_in_i), .cs_out_o(cs_out_o), .chan_o(chan_o)
  );

  int    nvec = 0;
  int    nbad = 0;
  int    cso_cnt = 0;
  bit    done = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  bit        sh_h[$];
  bit [7:0]  bus_h[$];
  bit [7:0]  exp_ch[NCH];
  bit        m_win = 0, m_cs_q = 0, m_last = 0, m_cso = 0;
  int        m_ptr = 0;

  initial begin
    for (int i = 0; i < S + 2; i++) begin
      sh_h.push_front(1'b0);
      bus_h.push_front(8'h00);
    end
    for (int i = 0; i < NCH; i++) exp_ch[i] = 8'h00;
  end

  always @(posedge clk) begin
    bit st, rise;
    sh_h.push_front(shclk_i);
    bus_h.push_front(bus_i);
    if (sh_h.size() > S + 2) begin
      void'(sh_h.pop_back());
      void'(bus_h.pop_back());
    end
    if (rst) begin
      for (int i = 0; i < NCH; i++) exp_ch[i] = 8'h00;
      m_win = 0; m_cs_q = 0; m_last = 0; m_cso = 0; m_ptr = 0;
    end else begin
      m_cso  = m_last;
      m_last = 0;
      st   = (sh_h[S] != sh_h[S+1]);
      rise = cs_in_i && !m_cs_q;
      m_cs_q = cs_in_i;
      if (!m_win) begin
        if (rise) begin m_win = 1; m_ptr = 0; end
      end else if (st) begin
        exp_ch[m_ptr] = bus_h[S];
        if (m_ptr == NCH - 1) begin
          m_win = 0; m_ptr = 0; m_last = 1;
        end else m_ptr++;
      end
    end
  end

  // per-cycle comparison and chip-select output bookkeeping
  bit cso_prev = 0;
  always @(negedge clk) begin
    logic [NCH*DW-1:0] ef;
    for (int i = 0; i < NCH; i++) ef[i*DW +: DW] = exp_ch[i];
    nvec++;
    if (chan_o !== ef || cs_out_o !== m_cso) begin
      nbad++;
      $display("FAIL %s cycle model: chan=%h cso=%b expected chan=%h cso=%b",
               cur_req, chan_o, cs_out_o, ef, m_cso);
    end
    if (cs_out_o && !cso_prev) cso_cnt++;
    cso_prev = cs_out_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int g, input int i);
    return 8'((i * 37 + g * 91 + 11) & 255);
  endfunction

  function automatic int lane(input int i);
    return int'(chan_o[i*DW +: DW]);
  endfunction

  task automatic shedge(input logic [7:0] b);
    @(negedge clk); bus_i = b;
    repeat (2) @(negedge clk);
    shclk_i = ~shclk_i;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_pulse();
    @(negedge clk); cs_in_i = 1'b1;
    @(negedge clk); cs_in_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end

  initial begin
    logic [NCH*DW-1:0] snap;
    int old0;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    chk(chan_o == '0, "R1 channels in reset", int'(chan_o[31:0]), 0);
    chk(cs_out_o == 1'b0, "R1 cs_out in reset", int'(cs_out_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    cur_req = "R6";
    for (int i = 0; i < 4; i++) shedge(8'hA5 + 8'(i));
    chk(chan_o == '0, "R6 edges without window", int'(chan_o[31:0]), 0);

    cur_req = "R2 R3 R5";
    cs_pulse();
    for (int i = 0; i < NCH; i++) shedge(pat(1, i));
    repeat (4) @(negedge clk);
    chk(lane(0) == int'(pat(1, 0)), "R2 rising edge to channel 1", lane(0), int'(pat(1, 0)));
    chk(lane(1) == int'(pat(1, 1)), "R2 falling edge to channel 2", lane(1), int'(pat(1, 1)));
    chk(lane(16) == int'(pat(1, 16)), "R3 channel 17", lane(16), int'(pat(1, 16)));
    chk(lane(31) == int'(pat(1, 31)), "R3 channel 32 top lane", lane(31), int'(pat(1, 31)));
    chk(cso_cnt == 1, "R5 one cs_out pulse per group", cso_cnt, 1);

    cur_req = "R4";
    snap = chan_o;
    for (int i = 0; i < 3; i++) shedge(8'hEE);
    chk(chan_o == snap, "R4 edges after window closed", lane(0), int'(snap[7:0]));
    chk(cso_cnt == 1, "R4 no extra cs_out", cso_cnt, 1);

    cur_req = "R7";
    cs_pulse();
    for (int i = 0; i < 10; i++) shedge(pat(2, i));
    cs_pulse();
    for (int i = 10; i < NCH; i++) shedge(pat(2, i));
    repeat (4) @(negedge clk);
    chk(lane(10) == int'(pat(2, 10)), "R7 mid-window cs_in ignored", lane(10), int'(pat(2, 10)));
    chk(lane(0) == int'(pat(2, 0)), "R7 channel 1 not rewritten", lane(0), int'(pat(2, 0)));
    chk(lane(31) == int'(pat(2, 31)), "R3 group two last channel", lane(31), int'(pat(2, 31)));
    chk(cso_cnt == 2, "R5 second group single pulse", cso_cnt, 2);

    cur_req = "R8";
    cs_pulse();
    old0 = lane(0);
    @(negedge clk); bus_i = 8'h5C;
    repeat (2) @(negedge clk);
    shclk_i = ~shclk_i;
    repeat (S) @(negedge clk);
    chk(lane(0) == old0, "R8 not yet visible", lane(0), old0);
    @(negedge clk);
    chk(lane(0) == 32'h5C, "R8 visible after two stages", lane(0), 32'h5C);
    repeat (3) @(negedge clk);
    for (int i = 1; i < NCH; i++) shedge(pat(3, i));
    repeat (4) @(negedge clk);
    chk(cso_cnt == 3, "R5 third group single pulse", cso_cnt, 3);
    chk(lane(5) == int'(pat(3, 5)), "R3 third group channel 6", lane(5), int'(pat(3, 5)));

    done = 1;
    finish_run();
  end
endmodule